// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Register File

This block holds the byte-wide control registers of a two-channel IDE bus-master controller inside a 16-byte I/O window. Each channel owns an 8-byte slice: four single-byte registers (command, a mode/interrupt byte shared by both channels, status, timing), then a 32-bit descriptor-table pointer. The descriptor walker and the drive-side protocol sit outside. They feed the block with per-channel interrupt requests and status events, and they read back the stored command, timing and pointer values.

The shared mode byte holds two kinds of bit. Hardware writes the pending bits, which follow each channel's interrupt input. Software writes the block bits. A single level-sensitive interrupt output is raised when at least one channel is pending and not blocked. The status byte mixes three rules: bits software may load, bits it can only clear by writing a one, and an activity bit that only the engine drives.

Top module: `ide_dma_regs`

## Requirements
- R1: Inside a channel's 4-byte group, address bits [1:0] select the register: 0 command, 1 shared mode byte, 2 status, 3 timing. A byte read returns the register in rdata[7:0] with zeros above it, and a byte write takes its data from wdata[7:0].
- R2: Address bit 3 selects the channel and bit 2 selects the pointer (1) or the byte group (0). Channel 0 uses offsets 0-7 and channel 1 uses 8-15. A write to one channel's command, status, timing or pointer leaves the other channel's copy unchanged.
- R3: Access size is encoded as 0 byte, 1 half-word, 2 or 3 word. A non-byte read of the byte group returns 0x0000FFFF for a half-word and 0xFFFFFFFF for a word. A non-byte write to the group changes nothing.
- R4: A write to the mode byte from either channel's offset 1 updates only bit 4 (block channel 0) and bit 5 (block channel 1). All other mode bits keep their value.
- R5: Mode bit 2 (channel 0 pending) and bit 3 (channel 1 pending) are set when the channel's interrupt input is high and cleared when it is low, one clock after the input is sampled.
- R6: irq_out is high exactly when (bit 2 set and bit 4 clear) or (bit 3 set and bit 5 clear). It is combinational from the mode byte, so it changes in the same cycle the mode byte does.
- R7: Each channel has its own 8-bit timing register at offset 3, which reads back the value last written to it.
- R8: While reset is low, every register is zero and irq_out is low.
- R9: Status bit 0 mirrors the channel's engine-active input with one cycle of delay. A status write loads bits 5 and 6 from the data. Bits 1 (error) and 2 (done) are set by engine pulses and cleared by writing 1 to them, and an engine set wins over a same-cycle clear. Bits 3, 4 and 7 read 0.
- R10: The 32-bit pointer accepts byte, half-word and word writes on lanes matching the address (lane k is wdata[8k+7:8k] for byte k). A word read returns the whole pointer. Bits [1:0] always read 0.
- R11: With req_valid low, rdata is zero and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 4 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| chan_irq | input | 2 | Per-channel interrupt request level |
| dma_active | input | 2 | Per-channel engine busy level |
| dma_err_set | input | 2 | Per-channel error event pulse |
| dma_done_set | input | 2 | Per-channel done event pulse |
| cmd_out | output | 16 | Command bytes, channel c in [8c+7:8c] |
| timing_out | output | 16 | Timing bytes, channel c in [8c+7:8c] |
| ptr_out | output | 64 | Pointers, channel c in [32c+31:32c] |
| irq_out | output | 1 | Combined interrupt level |

## Verification
Two pairs of actions can land in the same clock edge. An engine error pulse can coincide with a software write-one-to-clear of that same status bit. The bench drives both in one cycle and expects the bit to stay set, and it also checks that a lone clear does clear the bit. Separately, a block-bit write to the mode byte can coincide with a change of an interrupt input. The bench checks that the mode byte read back afterwards carries both the newly written block bits and the newly sampled pending bit, and that irq_out agrees with them.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   localparam logic [1:0] OFF_CMD  = 2'd0;
   localparam logic [1:0] OFF_MODE = 2'd1;
   localparam logic [1:0] OFF_STAT = 2'd2;
   localparam logic [1:0] OFF_TIM  = 2'd3;

   localparam int MODE_PEND_LSB = 2;
   localparam int MODE_BLK_LSB  = 4;
   localparam int STAT_ACT = 0;
   localparam int STAT_ERR = 1;
   localparam int STAT_DONE = 2;
endpackage

// File: rtl/ide_chan_regs.sv
module ide_chan_regs #(
   parameter int DW        = 32,
   parameter int ALIGN_LSB = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_cmd,
   input  logic            wr_stat,
   input  logic            wr_tim,
   input  logic [DW/8-1:0] ptr_be,
   input  logic [7:0]      wbyte,
   input  logic [DW-1:0]   wword,
   input  logic            eng_active,
   input  logic            eng_err,
   input  logic            eng_done,
   output logic [7:0]      cmd_q,
   output logic [7:0]      stat_q,
   output logic [7:0]      tim_q,
   output logic [DW-1:0]   ptr_q
);
   import ide_dma_pkg::*;
   localparam int NB = DW / 8;

   logic [7:0] stat_d;

   always_comb begin
      stat_d = 8'h00;
      stat_d[STAT_ACT]  = eng_active;
      stat_d[6:5]       = wr_stat ? wbyte[6:5] : stat_q[6:5];
      stat_d[STAT_ERR]  = eng_err  | (stat_q[STAT_ERR]  & ~(wr_stat & wbyte[STAT_ERR]));
      stat_d[STAT_DONE] = eng_done | (stat_q[STAT_DONE] & ~(wr_stat & wbyte[STAT_DONE]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= 8'h00;
         stat_q <= 8'h00;
         tim_q  <= 8'h00;
      end else begin
         if (wr_cmd) cmd_q <= wbyte;
         if (wr_tim) tim_q <= wbyte;
         stat_q <= stat_d;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_ptr
      if (b == 0) begin : g_low
         always_ff @(posedge clk) begin
            if (!rst_n) ptr_q[7:0] <= 8'h00;
            else if (ptr_be[0]) ptr_q[7:0] <= {wword[7:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
         end
      end else begin : g_hi
         always_ff @(posedge clk) begin
            if (!rst_n) ptr_q[8*b +: 8] <= 8'h00;
            else if (ptr_be[b]) ptr_q[8*b +: 8] <= wword[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/ide_mode_irq.sv
module ide_mode_irq #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] chan_irq,
   input  logic              wr_mode,
   input  logic [7:0]        wbyte,
   output logic [7:0]        mode_q,
   output logic              irq_out
);
   import ide_dma_pkg::*;

   logic [NUM_CH-1:0] pend, blk;
   assign pend = mode_q[MODE_PEND_LSB +: NUM_CH];
   assign blk  = mode_q[MODE_BLK_LSB  +: NUM_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 8'h00;
      end else begin
         mode_q[MODE_PEND_LSB +: NUM_CH] <= chan_irq;
         if (wr_mode) mode_q[MODE_BLK_LSB +: NUM_CH] <= wbyte[MODE_BLK_LSB +: NUM_CH];
      end
   end

   assign irq_out = |(pend & ~blk);
endmodule

// File: rtl/ide_dma_regs.sv
module ide_dma_regs
   import ide_dma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DW     = 32,
   parameter int AW     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [1:0]           req_size,
   input  logic [DW-1:0]        req_wdata,
   output logic [DW-1:0]        rdata,
   input  logic [NUM_CH-1:0]    chan_irq,
   input  logic [NUM_CH-1:0]    dma_active,
   input  logic [NUM_CH-1:0]    dma_err_set,
   input  logic [NUM_CH-1:0]    dma_done_set,
   output logic [NUM_CH*8-1:0]  cmd_out,
   output logic [NUM_CH*8-1:0]  timing_out,
   output logic [NUM_CH*DW-1:0] ptr_out,
   output logic                 irq_out
);
   localparam int NB     = DW / 8;
   localparam int CH_BIT = AW - 1;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("ide_dma_regs: mode byte layout fixes NUM_CH at 2");
   end
   if (DW != 32) begin : g_bad_dw
      $error("ide_dma_regs: pointer register is 32 bits");
   end
   if (AW != 4) begin : g_bad_aw
      $error("ide_dma_regs: window is 16 bytes");
   end

   logic [1:0]  off;
   logic        ch_sel, grp_sel, byte_acc, grp_wr, ptr_wr;
   logic [NB-1:0] be_base;
   logic [2*NB-1:0] be_shift;
   logic [7:0]  mode_q;
   logic [NUM_CH*8-1:0] stat_flat, tim_flat, cmd_flat;

   assign off      = req_addr[1:0];
   assign ch_sel   = req_addr[CH_BIT];
   assign grp_sel  = ~req_addr[2];
   assign byte_acc = (req_size == SZ_BYTE);
   assign grp_wr   = req_valid & req_write & grp_sel & byte_acc;
   assign ptr_wr   = req_valid & req_write & ~grp_sel;

   always_comb begin
      unique case (req_size)
         SZ_BYTE: be_base = NB'(4'b0001);
         SZ_HALF: be_base = NB'(4'b0011);
         default: be_base = {NB{1'b1}};
      endcase
      be_shift = {{NB{1'b0}}, be_base} << off;
   end

   ide_mode_irq #(.NUM_CH(NUM_CH)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .chan_irq(chan_irq),
      .wr_mode (grp_wr && off == OFF_MODE),
      .wbyte   (req_wdata[7:0]),
      .mode_q  (mode_q),
      .irq_out (irq_out)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = (ch_sel == c[0]);
      ide_chan_regs #(.DW(DW), .ALIGN_LSB(2)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_cmd    (grp_wr && hit && off == OFF_CMD),
         .wr_stat   (grp_wr && hit && off == OFF_STAT),
         .wr_tim    (grp_wr && hit && off == OFF_TIM),
         .ptr_be    ((ptr_wr && hit) ? be_shift[NB-1:0] : {NB{1'b0}}),
         .wbyte     (req_wdata[7:0]),
         .wword     (req_wdata),
         .eng_active(dma_active[c]),
         .eng_err   (dma_err_set[c]),
         .eng_done  (dma_done_set[c]),
         .cmd_q     (cmd_flat[8*c +: 8]),
         .stat_q    (stat_flat[8*c +: 8]),
         .tim_q     (tim_flat[8*c +: 8]),
         .ptr_q     (ptr_out[DW*c +: DW])
      );
   end

   assign cmd_out    = cmd_flat;
   assign timing_out = tim_flat;

   always_comb begin
      rdata = '0;
      if (req_valid) begin
         if (!grp_sel) begin
            rdata = ptr_out[DW*ch_sel +: DW];
         end else if (!byte_acc) begin
            rdata = (req_size == SZ_HALF) ? DW'(16'hFFFF) : {DW{1'b1}};
         end else begin
            unique case (off)
               OFF_CMD:  rdata[7:0] = cmd_flat[8*ch_sel +: 8];
               OFF_MODE: rdata[7:0] = mode_q;
               OFF_STAT: rdata[7:0] = stat_flat[8*ch_sel +: 8];
               default:  rdata[7:0] = tim_flat[8*ch_sel +: 8];
            endcase
         end
      end
   end
endmodule

// File: rtl/ide_dma_regs_chk.sv
module ide_dma_regs_chk #(
   parameter int NUM_CH = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [3:0]          req_addr,
   input logic [1:0]          req_size,
   input logic [31:0]         req_wdata,
   input logic [NUM_CH-1:0]   chan_irq,
   input logic [NUM_CH-1:0]   dma_err_set,
   input logic [7:0]          mode_q,
   input logic [NUM_CH*8-1:0] stat_flat,
   input logic [NUM_CH*8-1:0] tim_flat,
   input logic                irq_out
);
   logic grp_byte_wr, grp_wide_wr;
   assign grp_byte_wr = req_valid && req_write && !req_addr[2] && req_size == 2'd0;
   assign grp_wide_wr = req_valid && req_write && !req_addr[2] && req_size != 2'd0;

   assert_pend_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> mode_q[3:2] == $past(chan_irq));

   assert_blocked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[5:4] == 2'b11 |-> !irq_out);

   assert_wide_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_wide_wr |=> $stable(tim_flat));

   assert_mode_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_byte_wr && req_addr[1:0] == 2'd1) |=> mode_q[5:4] == $past(req_wdata[5:4]));

   assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_byte_wr && req_addr[1:0] == 2'd2 && !req_addr[3] && req_wdata[1] && !dma_err_set[0])
      |=> !stat_flat[1]);
endmodule

bind ide_dma_regs ide_dma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_size   (req_size),
   .req_wdata  (req_wdata),
   .chan_irq   (chan_irq),
   .dma_err_set(dma_err_set),
   .mode_q     (mode_q),
   .stat_flat  (stat_flat),
   .tim_flat   (tim_flat),
   .irq_out    (irq_out)
);

// File: tb/ide_dma_regs_test.sv
module ide_dma_regs_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        req_valid = 0, req_write = 0;
   logic [3:0]  req_addr = 0;
   logic [1:0]  req_size = 0;
   logic [31:0] req_wdata = 0;
   logic [31:0] rdata;
   logic [1:0]  chan_irq = 0, dma_active = 0, dma_err_set = 0, dma_done_set = 0;
   logic [15:0] cmd_out, timing_out;
   logic [63:0] ptr_out;
   logic        irq_out;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ide_dma_regs uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .rdata(rdata),
      .chan_irq(chan_irq), .dma_active(dma_active), .dma_err_set(dma_err_set),
      .dma_done_set(dma_done_set), .cmd_out(cmd_out), .timing_out(timing_out),
      .ptr_out(ptr_out), .irq_out(irq_out));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h want %08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic rd(logic [3:0] a, logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_size = s;
      #1 v = rdata;
      req_valid = 0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), (a[2] ? 2'd2 : 2'd0), v);
         check("R8 reset read", v, 0);
      end
      check("R8 reset irq", {31'd0, irq_out}, 0);
   endtask

   task automatic t_bytes;
      logic [31:0] v;
      wr(4'd3, 2'd0, 32'h0000_00A5);
      wr(4'd11, 2'd0, 32'h0000_003C);
      rd(4'd3, 2'd0, v);  check("R7 timing ch0", v, 32'hA5);
      rd(4'd11, 2'd0, v); check("R7 timing ch1", v, 32'h3C);
      check("R2 timing port", {16'd0, timing_out}, 32'h3CA5);
      wr(4'd8, 2'd0, 32'hFFFF_FF5A);
      rd(4'd8, 2'd0, v);  check("R1 cmd ch1 byte lane", v, 32'h5A);
      rd(4'd0, 2'd0, v);  check("R2 cmd ch0 untouched", v, 32'h00);
      @(negedge clk); req_addr = 4'd3; req_size = 0; #1;
      check("R11 idle rdata", rdata, 0);
   endtask

   task automatic t_wide;
      logic [31:0] v;
      wr(4'd3, 2'd1, 32'h0000_1111);
      wr(4'd11, 2'd2, 32'h2222_2222);
      rd(4'd3, 2'd0, v);  check("R3 half write ignored", v, 32'hA5);
      rd(4'd11, 2'd0, v); check("R3 word write ignored", v, 32'h3C);
      rd(4'd2, 2'd1, v);  check("R3 half read", v, 32'h0000_FFFF);
      rd(4'd9, 2'd2, v);  check("R3 word read", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_mode_irq;
      logic [31:0] v;
      wr(4'd1, 2'd0, 32'hFF);
      rd(4'd1, 2'd0, v);  check("R4 masked mode write", v, 32'h30);
      rd(4'd9, 2'd0, v);  check("R4 mode shared", v, 32'h30);
      wr(4'd1, 2'd0, 32'h00);
      @(negedge clk); chan_irq = 2'b01;
      @(negedge clk);
      check("R6 irq ch0 open", {31'd0, irq_out}, 1);
      rd(4'd1, 2'd0, v);  check("R5 pend ch0", v, 32'h04);
      wr(4'd9, 2'd0, 32'h10);
      check("R6 irq ch0 blocked", {31'd0, irq_out}, 0);
      // same-cycle block write and input change
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 4'd1; req_size = 0; req_wdata = 32'h20;
      chan_irq = 2'b11;
      @(negedge clk); req_valid = 0; req_write = 0;
      rd(4'd1, 2'd0, v);  check("R5 pend+block same cycle", v, 32'h2C);
      check("R6 irq ch0 reopened", {31'd0, irq_out}, 1);
      wr(4'd1, 2'd0, 32'h30);
      check("R6 irq both blocked", {31'd0, irq_out}, 0);
      @(negedge clk); chan_irq = 2'b00;
      wr(4'd1, 2'd0, 32'h00);
      rd(4'd1, 2'd0, v);  check("R5 pend cleared", v, 32'h00);
      check("R6 irq low", {31'd0, irq_out}, 0);
   endtask

   task automatic t_status;
      logic [31:0] v;
      wr(4'd2, 2'd0, 32'hFF);
      rd(4'd2, 2'd0, v);  check("R9 writable bits", v, 32'h60);
      @(negedge clk); dma_active[0] = 1;
      @(negedge clk); dma_err_set[0] = 1; dma_done_set[0] = 1;
      @(negedge clk); dma_err_set[0] = 0; dma_done_set[0] = 0;
      rd(4'd2, 2'd0, v);  check("R9 engine sets", v, 32'h67);
      rd(4'd10, 2'd0, v); check("R2 ch1 status untouched", v, 32'h00);
      wr(4'd2, 2'd0, 32'h62);
      rd(4'd2, 2'd0, v);  check("R9 clear err", v, 32'h65);
      @(negedge clk); dma_err_set[0] = 1;
      req_valid = 1; req_write = 1; req_addr = 4'd2; req_size = 0; req_wdata = 32'h66;
      @(negedge clk); req_valid = 0; req_write = 0; dma_err_set[0] = 0;
      rd(4'd2, 2'd0, v);  check("R9 set beats clear", v, 32'h63);
      @(negedge clk); dma_active[0] = 0;
      @(negedge clk);
      wr(4'd2, 2'd0, 32'h06);
      rd(4'd2, 2'd0, v);  check("R9 final clear", v, 32'h00);
   endtask

   task automatic t_ptr;
      logic [31:0] v;
      wr(4'd4, 2'd2, 32'h1234_5677);
      rd(4'd4, 2'd2, v);  check("R10 word aligned", v, 32'h1234_5674);
      wr(4'd6, 2'd0, 32'h00AB_0000);
      rd(4'd4, 2'd2, v);  check("R10 byte lane2", v, 32'h12AB_5674);
      wr(4'd12, 2'd1, 32'h0000_BEEF);
      rd(4'd12, 2'd2, v); check("R10 half ch1", v, 32'h0000_BEEC);
      wr(4'd14, 2'd0, 32'h00CD_0000);
      rd(4'd12, 2'd2, v); check("R10 byte ch1", v, 32'h00CD_BEEC);
      check("R2 ptr ch0 untouched", ptr_out[31:0], 32'h12AB_5674);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_bytes;
      t_wide;
      t_mode_irq;
      t_status;
      t_ptr;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout want completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule